// File: doc/BRIEF.md
# Inter-Crate Cable Bus Slave Decoder

This block is the receiving front end of a device on a multiplexed inter-crate cable bus. The shared lines are 32 address/data lines, 4 control lines and 5 identification lines, and their meaning changes between the two phases of a bus cycle. A cycle opens when the address strobe rises. In that address phase the block latches the target device number, the cycle type and the word address, and it decides whether this device takes part. It takes part when the device number equals its own, or in a broadcast when the number is zero.

While the address strobe stays high, each rising edge of the data strobe is one data transfer. On each transfer the block captures the identification lines and the data lines and issues a single-cycle local read or write strobe. For direct cycles the captured identification field is a register select. For transparent cycles it is address-extension bits. In a block transfer each successive transfer presents the next word address.

The local register file or bridge behind the block consumes the strobes, the captured field, the word address and the data. All inputs are sampled on the block clock. Both strobes are detected as rising edges between consecutive samples.

Top module: `cbus_slave_decode`

## Requirements
- R1: While reset is asserted, and on the first sample after it, sel_o, bcast_o, rd_stb_o and wr_stb_o are 0.
- R2: When the address strobe is first sampled high, the device is selected if id_i equals the nonzero own_dn_i. sel_o goes to 1 on that edge with bcast_o = 0.
- R3: Device number 0 gives a broadcast hit. The hit sets sel_o = 1 and bcast_o = 1 only when online_i and bcast_en_i are both 1; otherwise the device is not selected.
- R4: A nonzero device number different from own_dn_i leaves sel_o at 0, and no local strobe is issued for the whole cycle.
- R5: cyc_o reports the cycle type latched from cl_i (bit 3 is the most significant) as follows:
  - cl_i[3] = 1 gives direct, 0.
  - cl_i[3:2] = 00 gives transparent 64-bit address, 1. In this case ae_hi_o = cl_i[1:0].
  - 0100 gives transparent byte-lane aligned, 2.
  - 0111 gives transparent aligned, 3.
- R6: The reserved codes 0101 and 0110 are ignored. sel_o stays 0 and no strobe is issued until the address strobe falls.
- R7: In a selected cycle, each data-strobe rising edge gives exactly one cycle of rd_stb_o (write_i = 0) or wr_stb_o (write_i = 1), never both. The strobe appears on the edge that first samples ds_i high. Alongside it, fld_o carries id_i and wdata_o carries ad_i as sampled on that edge.
- R8: The word address ad_i[31:2] is latched in the address phase. The n-th transfer of the cycle (counting from 0) presents that word address plus n on waddr_o, with wrap modulo 2^30.
- R9: The edge that samples the address strobe low clears sel_o and bcast_o, and a following cycle is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_i | input | 1 | Address strobe, high for the whole cycle |
| ds_i | input | 1 | Data strobe, one rising edge per transfer |
| write_i | input | 1 | Transfer direction, 1 = write |
| ad_i | input | 32 | Address/data lines |
| cl_i | input | 4 | Control lines, cycle type in the address phase |
| id_i | input | 5 | Identification lines: device number, then register select or extension |
| own_dn_i | input | 5 | Static device number of this device |
| online_i | input | 1 | Device is online |
| bcast_en_i | input | 1 | Device accepts broadcast cycles |
| sel_o | output | 1 | Device takes part in the current cycle |
| bcast_o | output | 1 | Current cycle was selected by broadcast |
| cyc_o | output | 3 | Decoded cycle type |
| ae_hi_o | output | 2 | Address extension bits from the control lines |
| rd_stb_o | output | 1 | Single-cycle local read strobe |
| wr_stb_o | output | 1 | Single-cycle local write strobe |
| fld_o | output | 5 | Register select or extension field of the transfer |
| waddr_o | output | 30 | Word address of the transfer |
| wdata_o | output | 32 | Data of the transfer |

## Verification
sel_o, bcast_o, cyc_o and ae_hi_o are due one clock edge after the inputs that raise the address strobe are driven. A strobe with its field, address and data is due on the edge that first samples the data strobe high, and it is gone one edge later. sel_o drops on the edge that samples the address strobe low. The bench drives every input on the falling clock edge and samples half a period after each rising edge. Each check therefore lands exactly on the one-edge latency stated for its result, and the next sample confirms the strobe has ended.

// File: rtl/cbus_pkg.sv
package cbus_pkg;
  localparam int ID_W = 5;
  localparam int CL_W = 4;

  typedef enum logic [2:0] {
    CY_DIRECT = 3'd0,
    CY_T64    = 3'd1,
    CY_TBLA   = 3'd2,
    CY_TVME   = 3'd3,
    CY_RSV    = 3'd4
  } cyc_e;

  function automatic cyc_e cyc_decode(input logic [CL_W-1:0] cl);
    if (cl[3])              return CY_DIRECT;
    else if (!cl[2])        return CY_T64;
    else if (cl[1:0] == 2'b00) return CY_TBLA;
    else if (cl[1:0] == 2'b11) return CY_TVME;
    else                    return CY_RSV;
  endfunction

  // returns {hit, broadcast}
  function automatic logic [1:0] dev_match(input logic [ID_W-1:0] dn,
                                           input logic [ID_W-1:0] own,
                                           input logic online,
                                           input logic ben);
    if (dn == '0) return {online & ben, online & ben};
    else          return {dn == own, 1'b0};
  endfunction
endpackage

// File: rtl/cbus_phase_trk.sv
module cbus_phase_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic as_i,
  input  logic ds_i,
  output logic as_rise_o,
  output logic ds_rise_o
);
  logic as_q, ds_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      as_q <= 1'b0;
      ds_q <= 1'b0;
    end else begin
      as_q <= as_i;
      ds_q <= ds_i;
    end
  end

  assign as_rise_o = as_i & ~as_q;
  assign ds_rise_o = ds_i & ~ds_q;

  a_r7_ds_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
    ds_rise_o |=> !ds_rise_o);
endmodule

// File: rtl/cbus_addr_latch.sv
module cbus_addr_latch
  import cbus_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_i,
  input  logic            as_rise_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] own_dn_i,
  input  logic            online_i,
  input  logic            bcast_en_i,
  output logic            act_o,
  output logic            bcast_o,
  output cyc_e            cyc_o,
  output logic [1:0]      ae_hi_o
);
  cyc_e       cyc_now;
  logic [1:0] match_now;

  assign cyc_now   = cyc_decode(cl_i);
  assign match_now = dev_match(id_i, own_dn_i, online_i, bcast_en_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_o   <= 1'b0;
      bcast_o <= 1'b0;
      cyc_o   <= CY_DIRECT;
      ae_hi_o <= 2'b00;
    end else if (as_rise_i) begin
      act_o   <= match_now[1] && (cyc_now != CY_RSV);
      bcast_o <= match_now[0] && (cyc_now != CY_RSV);
      cyc_o   <= cyc_now;
      ae_hi_o <= cl_i[1:0];
    end else if (!as_i) begin
      act_o   <= 1'b0;
      bcast_o <= 1'b0;
    end
  end

  a_r6_no_reserved_sel: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> cyc_o != CY_RSV);
  a_r3_bcast_implies_sel: assert property (@(posedge clk) disable iff (!rst_n)
    bcast_o |-> act_o);
  a_r9_drop_on_as_low: assert property (@(posedge clk) disable iff (!rst_n)
    !as_i |=> !act_o);
endmodule

// File: rtl/cbus_xfer_gen.sv
module cbus_xfer_gen
  import cbus_pkg::*;
#(
  parameter int AD_W = 32,
  localparam int WA_W = AD_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_i,
  input  logic            as_rise_i,
  input  logic            ds_rise_i,
  input  logic            act_i,
  input  logic            write_i,
  input  logic [WA_W-1:0] wa_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [ID_W-1:0] id_i,
  output logic            rd_stb_o,
  output logic            wr_stb_o,
  output logic [ID_W-1:0] fld_o,
  output logic [WA_W-1:0] waddr_o,
  output logic [AD_W-1:0] wdata_o
);
  logic [WA_W-1:0] wa_cnt;
  logic            fire;

  assign fire = ds_rise_i & act_i & as_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wa_cnt   <= '0;
      rd_stb_o <= 1'b0;
      wr_stb_o <= 1'b0;
      fld_o    <= '0;
      waddr_o  <= '0;
      wdata_o  <= '0;
    end else begin
      rd_stb_o <= fire & ~write_i;
      wr_stb_o <= fire & write_i;
      if (as_rise_i) begin
        wa_cnt <= wa_i;
      end else if (fire) begin
        wa_cnt <= wa_cnt + 1'b1;
      end
      if (fire) begin
        fld_o   <= id_i;
        waddr_o <= wa_cnt;
        wdata_o <= ad_i;
      end
    end
  end

  a_r7_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_stb_o, wr_stb_o}));
  a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |=> !(rd_stb_o || wr_stb_o));
  a_r4_strobe_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb_o || wr_stb_o) |-> act_i);
  a_r8_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !as_rise_i) |=> wa_cnt == waddr_o + 1'b1);
endmodule

// File: rtl/cbus_slave_decode.sv
module cbus_slave_decode
  import cbus_pkg::*;
#(
  parameter int AD_W = 32,
  localparam int WA_W = AD_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            as_i,
  input  logic            ds_i,
  input  logic            write_i,
  input  logic [AD_W-1:0] ad_i,
  input  logic [CL_W-1:0] cl_i,
  input  logic [ID_W-1:0] id_i,
  input  logic [ID_W-1:0] own_dn_i,
  input  logic            online_i,
  input  logic            bcast_en_i,
  output logic            sel_o,
  output logic            bcast_o,
  output logic [2:0]      cyc_o,
  output logic [1:0]      ae_hi_o,
  output logic            rd_stb_o,
  output logic            wr_stb_o,
  output logic [ID_W-1:0] fld_o,
  output logic [WA_W-1:0] waddr_o,
  output logic [AD_W-1:0] wdata_o
);
  logic as_rise, ds_rise, act;
  cyc_e cyc_q;

  cbus_phase_trk u_trk (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i),
    .as_rise_o(as_rise), .ds_rise_o(ds_rise)
  );

  cbus_addr_latch u_lat (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .as_rise_i(as_rise),
    .cl_i(cl_i), .id_i(id_i), .own_dn_i(own_dn_i), .online_i(online_i),
    .bcast_en_i(bcast_en_i), .act_o(act), .bcast_o(bcast_o),
    .cyc_o(cyc_q), .ae_hi_o(ae_hi_o)
  );

  cbus_xfer_gen #(.AD_W(AD_W)) u_xfr (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .as_rise_i(as_rise),
    .ds_rise_i(ds_rise), .act_i(act), .write_i(write_i),
    .wa_i(ad_i[AD_W-1:2]), .ad_i(ad_i), .id_i(id_i),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .fld_o(fld_o),
    .waddr_o(waddr_o), .wdata_o(wdata_o)
  );

  assign sel_o = act;
  assign cyc_o = cyc_q;
endmodule

// File: tb/tb_cbus_slave_decode.sv
module tb_cbus_slave_decode;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] OWN = 5'd5;

  typedef struct packed {
    logic [3:0]  cl;
    logic [4:0]  dn;
    logic        onl;
    logic        ben;
    logic        wr;
    logic [31:0] addr;
    logic        sel;
    logic        bc;
    logic [2:0]  cyc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{4'b1000, 5'd5, 1'b1, 1'b0, 1'b1, 32'h0000_0040, 1'b1, 1'b0, 3'd0},
    '{4'b0011, 5'd5, 1'b1, 1'b0, 1'b1, 32'h1234_5678, 1'b1, 1'b0, 3'd1},
    '{4'b0100, 5'd5, 1'b0, 1'b0, 1'b0, 32'h0000_1000, 1'b1, 1'b0, 3'd2},
    '{4'b0111, 5'd5, 1'b1, 1'b1, 1'b1, 32'h8000_0004, 1'b1, 1'b0, 3'd3},
    '{4'b1000, 5'd0, 1'b1, 1'b1, 1'b1, 32'h0000_0100, 1'b1, 1'b1, 3'd0},
    '{4'b1000, 5'd0, 1'b0, 1'b1, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 3'd0},
    '{4'b1000, 5'd0, 1'b1, 1'b0, 1'b1, 32'h0000_0100, 1'b0, 1'b0, 3'd0},
    '{4'b1000, 5'd9, 1'b1, 1'b1, 1'b1, 32'h0000_0200, 1'b0, 1'b0, 3'd0},
    '{4'b0101, 5'd5, 1'b1, 1'b1, 1'b1, 32'h0000_0300, 1'b0, 1'b0, 3'd0},
    '{4'b0110, 5'd5, 1'b1, 1'b1, 1'b0, 32'h0000_0400, 1'b0, 1'b0, 3'd0},
    '{4'b1010, 5'd5, 1'b1, 1'b0, 1'b0, 32'hFFFF_FFFC, 1'b1, 1'b0, 3'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic as_i = 0, ds_i = 0, write_i = 0, online_i = 0, bcast_en_i = 0;
  logic [31:0] ad_i = '0;
  logic [3:0] cl_i = '0;
  logic [4:0] id_i = '0;
  logic sel_o, bcast_o, rd_stb_o, wr_stb_o;
  logic [2:0] cyc_o;
  logic [1:0] ae_hi_o;
  logic [4:0] fld_o;
  logic [29:0] waddr_o;
  logic [31:0] wdata_o;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cbus_slave_decode dut (
    .clk(clk), .rst_n(rst_n), .as_i(as_i), .ds_i(ds_i), .write_i(write_i),
    .ad_i(ad_i), .cl_i(cl_i), .id_i(id_i), .own_dn_i(OWN),
    .online_i(online_i), .bcast_en_i(bcast_en_i), .sel_o(sel_o),
    .bcast_o(bcast_o), .cyc_o(cyc_o), .ae_hi_o(ae_hi_o),
    .rd_stb_o(rd_stb_o), .wr_stb_o(wr_stb_o), .fld_o(fld_o),
    .waddr_o(waddr_o), .wdata_o(wdata_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 sel", {31'd0, sel_o}, 0);
    chk("R1 strobes", {30'd0, rd_stb_o, wr_stb_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {29'd0, sel_o, bcast_o, rd_stb_o | wr_stb_o}, 0);

    for (int i = 0; i < NV; i++) begin
      automatic vec_t v = VEC[i];
      automatic logic [29:0] base = v.addr[31:2];
      automatic logic [31:0] d1 = 32'hA500_0000 + i;
      automatic logic [31:0] d2 = 32'h5A00_0100 + i;
      automatic logic [4:0] rs1 = 5'(i + 3);
      automatic logic [4:0] rs2 = 5'(31 - i);
      online_i = v.onl; bcast_en_i = v.ben;
      as_i = 1; ad_i = v.addr; cl_i = v.cl; id_i = v.dn;
      @(negedge clk);
      chk("R2/R3/R4/R6 sel", {31'd0, sel_o}, {31'd0, v.sel});
      chk("R3 bcast", {31'd0, bcast_o}, {31'd0, v.bc});
      if (v.sel) chk("R5 cyc", {29'd0, cyc_o}, {29'd0, v.cyc});
      if (v.sel && v.cyc == 3'd1) chk("R5 ae", {30'd0, ae_hi_o}, {30'd0, v.cl[1:0]});
      ad_i = d1; id_i = rs1; write_i = v.wr; ds_i = 1;
      @(negedge clk);
      if (v.sel) begin
        chk("R7 rd", {31'd0, rd_stb_o}, {31'd0, ~v.wr});
        chk("R7 wr", {31'd0, wr_stb_o}, {31'd0, v.wr});
        chk("R7 fld", {27'd0, fld_o}, {27'd0, rs1});
        chk("R7 data", wdata_o, d1);
        chk("R8 first addr", {2'd0, waddr_o}, {2'd0, base});
      end else begin
        chk("R4/R6 no strobe", {31'd0, rd_stb_o | wr_stb_o}, 0);
      end
      @(negedge clk);
      chk("R7 single pulse", {31'd0, rd_stb_o | wr_stb_o}, 0);
      ds_i = 0;
      @(negedge clk);
      ad_i = d2; id_i = rs2; ds_i = 1;
      @(negedge clk);
      if (v.sel) begin
        chk("R8 next addr", {2'd0, waddr_o}, {2'd0, base + 30'd1});
        chk("R7 fld2", {27'd0, fld_o}, {27'd0, rs2});
        chk("R7 data2", wdata_o, d2);
      end else begin
        chk("R4/R6 no strobe2", {31'd0, rd_stb_o | wr_stb_o}, 0);
      end
      ds_i = 0; as_i = 0;
      @(negedge clk);
      chk("R9 sel drop", {30'd0, sel_o, bcast_o}, 0);
      @(negedge clk);
    end

    // R9: reserved cycle followed immediately by a valid one is decoded afresh
    online_i = 1; bcast_en_i = 0;
    as_i = 1; cl_i = 4'b0110; id_i = OWN; ad_i = 32'h10;
    @(negedge clk);
    chk("R6 reserved", {31'd0, sel_o}, 0);
    as_i = 0;
    @(negedge clk);
    as_i = 1; cl_i = 4'b1100;
    @(negedge clk);
    chk("R9 fresh cycle", {31'd0, sel_o}, 1);
    as_i = 0;
    @(negedge clk);
    finish_run();
  end
endmodule